// File: doc/BRIEF.md
# Group-Skipping Binary Adder

This block adds two unsigned operands and an incoming carry, producing a sum of the same width and a final carry. The operand bits are split into equal groups, four bits wide by default. Inside each group, a chain of full adders ripples the carry from bit to bit. Each bit also forms a generate term (both operand bits set) and a propagate term (operand bits differ).

When every bit of a group propagates, a multiplexer sends the group's incoming carry straight to the next group and skips that group's chain. In every other case, the group's outgoing carry is the one its own chain produces, either generated or killed. The sum bits of a group are always formed from the true incoming carry, so the sum is exact however the carry reached the group.

The adder core is combinational. One result register sits behind it with a valid/ready handshake, which gives the pipeline one cycle of latency.

Handshake rules:
- An operand set is accepted on any rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the result register is empty or is being drained in the same cycle, so back-pressure reaches the input with no added delay.
- A result that is presented but not taken stays unchanged until `out_ready` goes high.

Top module: `skip_adder`

## Requirements
- R1: `out_sum` equals the low WIDTH bits of in_a + in_b + in_cin, taken from the accepted operand set.
- R2: `out_cout` equals bit WIDTH of the full-precision sum in_a + in_b + in_cin.
- R3: When all propagate bits of a group are 1 (the two operand bits differ at every position), that group's carry-out equals its carry-in. For example, in_a = ~in_b with in_cin = 1 gives a sum of all zeros and a carry-out of 1.
- R4: When a group is not all-propagate, its carry-out comes from its local chain. A generate at the group's top bit (both bits 1) forces a carry-out of 1, and a kill there (both bits 0) forces a carry-out of 0.
- R5: The sum bits of every group reflect that group's true carry-in. With in_a = ~in_b, the sum is all ones when in_cin = 0 and all zeros when in_cin = 1.
- R6: An operand set accepted at a rising edge is presented with `out_valid` high after that same edge. `out_valid` is low after reset.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum` and `out_cout` hold their values.
- R8: `in_ready` equals the inverse of `out_valid`, ORed with `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be accepted |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_cin | input | 1 | Incoming carry |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Result taken by the consumer |
| out_sum | output | WIDTH | Sum |
| out_cout | output | 1 | Final carry |

## Verification
The bench goes after operands where whole groups propagate, such as complementary operands with either carry-in. A design that selected the skip path from the wrong condition, or that formed sums from the stale local carry, would show a wrong carry-out or a wrong run of sum bits there.

Group-top generate and kill patterns catch a skip multiplexer whose inputs are swapped: a carry would leak through, or be lost, at a group boundary. Long stalls on `out_ready` catch a result register that overwrites a result nobody has taken, or that drops a handshake.

// File: rtl/skip_adder_pkg.sv
package skip_adder_pkg;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_GROUP = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } bit_pg_t;

  function automatic bit_pg_t make_pg(input logic a, input logic b);
    bit_pg_t r;
    r.gen  = a & b;
    r.prop = a ^ b;
    return r;
  endfunction
endpackage

// File: rtl/skip_full_adder.sv
module skip_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a | b));
endmodule

// File: rtl/skip_pg_setup.sv
module skip_pg_setup
  import skip_adder_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    bit_pg_t pg;
    assign pg      = make_pg(a[i], b[i]);
    assign gen[i]  = pg.gen;
    assign prop[i] = pg.prop;
  end
endmodule

// File: rtl/skip_group.sv
module skip_group #(
  parameter int unsigned GROUP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GROUP-1:0] a,
  input  logic [GROUP-1:0] b,
  input  logic [GROUP-1:0] gen,
  input  logic [GROUP-1:0] prop,
  input  logic             cin,
  output logic [GROUP-1:0] sum,
  output logic             cout
);
  logic chain [GROUP+1];
  logic skip_sel;

  assign chain[0] = cin;

  for (genvar i = 0; i < GROUP; i++) begin : g_fa
    skip_full_adder i_fa (
      .a  (a[i]),
      .b  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign skip_sel = &prop;
  assign cout     = skip_sel ? cin : chain[GROUP];

  AST_SKIP_MATCHES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    skip_sel |-> (chain[GROUP] == cin)); // R3
  AST_TOP_GEN_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    gen[GROUP-1] |-> cout); // R4
  AST_TOP_KILL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!a[GROUP-1] && !b[GROUP-1]) |-> !cout); // R4
endmodule

// File: rtl/skip_adder.sv
module skip_adder
  import skip_adder_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_cin,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_cout
);
  localparam int unsigned NGRP = WIDTH / GROUP;

  initial assert (NGRP * GROUP == WIDTH);

  logic [WIDTH-1:0] gen, prop, sum_c;
  logic             gcarry [NGRP+1];
  logic             fire_in;

  skip_pg_setup #(.WIDTH(WIDTH)) i_setup (
    .a    (in_a),
    .b    (in_b),
    .gen  (gen),
    .prop (prop)
  );

  assign gcarry[0] = in_cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    skip_group #(.GROUP(GROUP)) i_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (in_a[k*GROUP +: GROUP]),
      .b     (in_b[k*GROUP +: GROUP]),
      .gen   (gen[k*GROUP +: GROUP]),
      .prop  (prop[k*GROUP +: GROUP]),
      .cin   (gcarry[k]),
      .sum   (sum_c[k*GROUP +: GROUP]),
      .cout  (gcarry[k+1])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign fire_in  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_cout  <= 1'b0;
    end else if (fire_in) begin
      out_valid <= 1'b1;
      out_sum   <= sum_c;
      out_cout  <= gcarry[NGRP];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_RESULT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> ({out_cout, out_sum} ==
      ({1'b0, $past(in_a)} + {1'b0, $past(in_b)} + {{WIDTH{1'b0}}, $past(in_cin)}))); // R1 R2
  AST_ACCEPT_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> out_valid); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_cout))); // R7
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
endmodule

// File: tb/test_skip_adder.sv
module test_skip_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_sum;
  logic         out_cout;

  int total = 0;
  int failed = 0;

  // reference model state
  bit           m_valid = 0;
  bit [W-1:0]   m_sum;
  bit           m_cout;
  string        m_tag = "";
  bit           p_v = 0, p_ordy = 0, p_cin = 0;
  bit [W-1:0]   p_a, p_b;
  string        p_tag = "";

  always #4 clk = ~clk;

  skip_adder i_skip_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_cout(out_cout)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input bit [W-1:0] a, input bit [W-1:0] b,
                       input bit ci, input bit ordy, input string tag);
    bit [W:0] full;
    bit       stalled;
    @(negedge clk);
    stalled = m_valid && !p_ordy;
    if (p_v && (!m_valid || p_ordy)) begin
      full    = {1'b0, p_a} + {1'b0, p_b} + {{W{1'b0}}, p_cin};
      m_valid = 1;
      m_sum   = full[W-1:0];
      m_cout  = full[W];
      m_tag   = p_tag;
    end else if (m_valid && p_ordy) begin
      m_valid = 0;
    end
    chk(out_valid == m_valid, stalled ? "R7 valid held" : "R6 valid", out_valid, m_valid);
    if (m_valid) begin
      chk(out_sum == m_sum, {stalled ? "R7 " : "", "R1 sum ", m_tag}, out_sum, m_sum);
      chk(out_cout == m_cout, {stalled ? "R7 " : "", "R2 cout ", m_tag}, out_cout, m_cout);
    end
    in_valid = v; in_a = a; in_b = b; in_cin = ci; out_ready = ordy;
    p_v = v; p_a = a; p_b = b; p_cin = ci; p_ordy = ordy; p_tag = tag;
    #1;
    chk(in_ready == (!m_valid || ordy), "R8 in_ready", in_ready, !m_valid || ordy);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset valid", out_valid, 0);
    chk(in_ready == 1'b1, "R8 reset ready", in_ready, 1);
    rst_n = 1'b1;
    // R3 R5: complementary operands, whole word propagates
    cycle(1, 16'h5555, 16'hAAAA, 0, 1, "R5 comp cin0");
    cycle(1, 16'h5555, 16'hAAAA, 1, 1, "R3 R5 comp cin1");
    cycle(1, 16'h1234, 16'hEDCB, 1, 1, "R3 R5 comp2 cin1");
    cycle(1, 16'h0000, 16'hFFFF, 0, 1, "R5 zero/ones cin0");
    // R4: generate at group tops, kill at group tops
    cycle(1, 16'h8888, 16'h8888, 0, 1, "R4 top generate");
    cycle(1, 16'h000F, 16'h0001, 0, 1, "R4 chain carry into group1");
    cycle(1, 16'h0777, 16'h0009, 0, 1, "R4 top kill");
    cycle(1, 16'hFFFF, 16'h0001, 0, 1, "R4 full ripple");
    // mixed: low group propagates, upper groups generate/kill
    cycle(1, 16'hF00A, 16'hF005, 1, 1, "R3 low group skip");
    cycle(1, 16'hFFFF, 16'hFFFF, 1, 1, "R2 all generate");
    // R7: hold under stall
    cycle(1, 16'h4321, 16'h1111, 0, 0, "R7 stall load");
    cycle(1, 16'h9999, 16'h9999, 1, 0, "R7 stall blocked");
    cycle(0, 16'h0, 16'h0, 0, 0, "idle");
    cycle(0, 16'h0, 16'h0, 0, 1, "drain");
    cycle(0, 16'h0, 16'h0, 0, 1, "idle");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit [W-1:0] ra = W'($urandom);
      bit [W-1:0] rb = W'($urandom);
      if (n % 5 == 0) rb = ~ra;
      cycle(($urandom % 4) != 0, ra, rb, 1'($urandom), ($urandom % 4) != 0, "random");
    end
    cycle(0, 16'h0, 16'h0, 0, 1, "flush");
    cycle(0, 16'h0, 16'h0, 0, 1, "flush");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule